// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small processor, built as a microcoded sequencer. A 5-bit micro program counter selects one word of an internal 32-word micro-ROM. The selected word is held in a micro instruction register. The 12-bit control field of that register drives the control vector that enables, clocks and selects the rest of the datapath. Each micro word also carries a 2-bit next-address type and a 5-bit link field, and together they decide where the sequencer goes next.

The state of the sequencer is the current micro address, so each state is one micro word. There are four named groups of states:

- **FETCH0..FETCH3** (addresses 0 to 3) form the fetch routine.
- **DISPATCH** is the last fetch step (FETCH3). From it the sequencer jumps through the opcode lookup table.
- **ROUTINE(op)** is the run of words that executes one opcode.
- **RETURN** is the last word of every routine. It sends the sequencer back to FETCH0.

There are four named transitions:

- **STEP** moves to the next address up (type 00).
- **MAP** moves to the start of the opcode's routine (type 01).
- **LINK** moves to the address in the link field (type 10).
- **HOME** moves to address 0 (type 11).

The host drives the 3-bit opcode taken from its instruction register. The opcode is looked at only while the sequencer sits on DISPATCH.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the sequencer goes to micro address 0. In the cycle after that edge, `uaddr_o` is 0 and `ctrl_o` is the control word of address 0.
- R2: `ctrl_o` always equals the control word of the current `uaddr_o`. For an address a below 24, the control word is {a XOR 5'h15, 2'b10, a}, with a in bits 4:0. For addresses 24 to 31 the control word is 0.
- R3: After reset, the fetch routine passes through addresses 0, 1, 2 and 3, one cycle each.
- R4: The word at address 3 uses type 01. The next address is the start of the routine for the opcode present in that cycle. The routine starts for opcodes 0 to 7 are 4, 5, 7, 9, 12, 15, 19 and 21.
- R5: Inside a routine, every word except the last uses type 00 and advances by one. The routine lengths for opcodes 0 to 7 are 1, 2, 2, 3, 3, 4, 2 and 3 words.
- R6: The last word of the routines for opcodes 0 to 6 uses type 10 with a link field of 0, so the next address is 0.
- R7: Type 11 returns the sequencer to address 0 whatever the link field holds. The last word of the opcode-7 routine (address 23) uses type 11 with a link field of 31, and the sequencer still goes to 0.
- R8: A change of the opcode in any cycle other than the one spent at address 3 has no effect on the address trace.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 3 | Opcode from the host instruction register |
| ctrl_o | output | 12 | Control vector from the micro instruction register |
| uaddr_o | output | 5 | Current micro address |

## Verification
A new address and its control word appear together one clock edge after the cycle in which the sequencer decided on them. For the dispatch step, this means the opcode present during the cycle at address 3 determines the address seen after the next edge. The bench drives the opcode at the falling edge and, at the same moment, computes the expected next address from the routine tables using that opcode. It then compares both outputs at the following falling edge, one full edge of latency later. A reset check is sampled at the falling edge that follows the first rising edge with `rst` high.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UA_W      = 5;
    localparam int CTRL_W    = 12;
    localparam int OP_W      = 3;
    localparam int ROM_DEPTH = 1 << UA_W;
    localparam int N_OPS     = 1 << OP_W;
    localparam int FETCH_LEN = 4;
    localparam int DISPATCH  = FETCH_LEN - 1;
    localparam int TAG_W     = 2;
    localparam logic [UA_W-1:0] HOME_ADDR  = '0;
    localparam logic [UA_W-1:0] ODD_LINK   = '1;
    localparam logic [UA_W-1:0] CTRL_SALT  = 5'h15;

    typedef enum logic [TAG_W-1:0] {
        NX_STEP = 2'b00,
        NX_MAP  = 2'b01,
        NX_LINK = 2'b10,
        NX_HOME = 2'b11
    } nxt_t;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        nxt_t              nxt;
        logic [UA_W-1:0]   link;
    } uword_t;

    function automatic int route_len(input int op);
        unique case (op)
            0:       return 1;
            1, 2, 6: return 2;
            3, 4, 7: return 3;
            5:       return 4;
            default: return 1;
        endcase
    endfunction

    function automatic int route_start(input int op);
        int s;
        s = FETCH_LEN;
        for (int j = 0; j < op; j++) s += route_len(j);
        return s;
    endfunction

    function automatic int code_end();
        return route_start(N_OPS);
    endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
(
    input  logic [UA_W-1:0] addr_i,
    output uword_t          word_o
);

    function automatic uword_t build_word(input int a);
        uword_t w;
        logic [UA_W-1:0] av;
        av     = UA_W'(a);
        w.ctrl = (a < code_end()) ? {av ^ CTRL_SALT, 2'b10, av} : '0;
        w.nxt  = NX_HOME;
        w.link = HOME_ADDR;
        if (a < DISPATCH) begin
            w.nxt = NX_STEP;
        end else if (a == DISPATCH) begin
            w.nxt = NX_MAP;
        end else if (a < code_end()) begin
            for (int op = 0; op < N_OPS; op++) begin
                if (a >= route_start(op) && a < route_start(op) + route_len(op)) begin
                    if (a != route_start(op) + route_len(op) - 1) begin
                        w.nxt = NX_STEP;
                    end else if (op == N_OPS - 1) begin
                        w.nxt  = NX_HOME;
                        w.link = ODD_LINK;
                    end else begin
                        w.nxt = NX_LINK;
                    end
                end
            end
        end
        return w;
    endfunction

    uword_t store [ROM_DEPTH];

    for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_word
        assign store[g] = build_word(g);
    end

    assign word_o = store[addr_i];

endmodule

// File: rtl/useq_opmap.sv
module useq_opmap
    import useq_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output logic [UA_W-1:0] start_o
);

    logic [UA_W-1:0] table_q [N_OPS];

    for (genvar g = 0; g < N_OPS; g++) begin : g_entry
        assign table_q[g] = UA_W'(route_start(g));
    end

    assign start_o = table_q[op_i];

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  logic [UA_W-1:0] upc_i,
    input  uword_t          uir_i,
    input  logic [UA_W-1:0] map_i,
    output logic [UA_W-1:0] upc_nxt_o
);

    always_comb begin
        unique case (uir_i.nxt)
            NX_STEP: upc_nxt_o = UA_W'(upc_i + 1'b1);
            NX_MAP:  upc_nxt_o = map_i;
            NX_LINK: upc_nxt_o = uir_i.link;
            NX_HOME: upc_nxt_o = HOME_ADDR;
            default: upc_nxt_o = HOME_ADDR;
        endcase
    end

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   opcode_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [UA_W-1:0]   uaddr_o
);

    logic [UA_W-1:0] upc_q;
    uword_t          uir_q;
    logic [UA_W-1:0] upc_nxt;
    logic [UA_W-1:0] map_addr;
    logic [UA_W-1:0] rom_addr;
    uword_t          rom_word;

    useq_opmap u_map (
        .op_i    (opcode_i),
        .start_o (map_addr)
    );

    useq_next u_next (
        .upc_i     (upc_q),
        .uir_i     (uir_q),
        .map_i     (map_addr),
        .upc_nxt_o (upc_nxt)
    );

    assign rom_addr = rst ? HOME_ADDR : upc_nxt;

    useq_rom u_rom (
        .addr_i (rom_addr),
        .word_o (rom_word)
    );

    // State register: micro address and the word fetched for it move together.
    always_ff @(posedge clk) begin
        upc_q <= rom_addr;
        uir_q <= rom_word;
    end

    // Outputs straight from the registers.
    always_comb begin
        ctrl_o  = uir_q.ctrl;
        uaddr_o = upc_q;
    end

    a_r1_reset_home: assert property (@(posedge clk)
        rst |=> (upc_q == HOME_ADDR));

    a_r3_step_adds_one: assert property (@(posedge clk) disable iff (rst)
        (uir_q.nxt == NX_STEP) |=> (upc_q == UA_W'($past(upc_q) + 1'b1)));

    a_r4_map_dispatch: assert property (@(posedge clk) disable iff (rst)
        (uir_q.nxt == NX_MAP) |=> (upc_q == $past(map_addr)));

    a_r6_link_follows: assert property (@(posedge clk) disable iff (rst)
        (uir_q.nxt == NX_LINK) |=> (upc_q == $past(uir_q.link)));

    a_r7_home_return: assert property (@(posedge clk) disable iff (rst)
        (uir_q.nxt == NX_HOME) |=> (upc_q == HOME_ADDR));

    a_r4_map_only_at_dispatch: assert property (@(posedge clk) disable iff (rst)
        (uir_q.nxt == NX_MAP) |-> (upc_q == UA_W'(DISPATCH)));

endmodule

// File: tb/sim_ucode_sequencer.sv
module sim_ucode_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  opcode = 3'd0;
    logic [11:0] ctrl;
    logic [4:0]  uaddr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    int exp_a    = 0;

    always #4 clk = ~clk;

    ucode_sequencer u0 (
        .clk      (clk),
        .rst      (rst),
        .opcode_i (opcode),
        .ctrl_o   (ctrl),
        .uaddr_o  (uaddr)
    );

    function automatic int t_len(input int op);
        int l [8] = '{1, 2, 2, 3, 3, 4, 2, 3};
        return l[op];
    endfunction

    function automatic int t_start(input int op);
        int s [8] = '{4, 5, 7, 9, 12, 15, 19, 21};
        return s[op];
    endfunction

    function automatic logic [11:0] exp_ctrl(input int a);
        logic [4:0] av;
        av = 5'(a);
        return (a < 24) ? {av ^ 5'h15, 2'b10, av} : 12'h000;
    endfunction

    function automatic int model_next(input int a, input int op);
        if (a < 3)  return a + 1;
        if (a == 3) return t_start(op);
        for (int k = 0; k < 8; k++)
            if (a >= t_start(k) && a < t_start(k) + t_len(k))
                return (a == t_start(k) + t_len(k) - 1) ? 0 : a + 1;
        return 0;
    endfunction

    function automatic string tag_for(input int prev, input int nxt);
        if (prev < 3)  return "R3";
        if (prev == 3) return "R4";
        if (nxt != 0)  return "R5";
        if (prev == 23) return "R7";
        return "R6";
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // At a falling edge: drive op, predict, wait one edge, compare.
    task automatic step(input int op, input bit rnd);
        int nxt;
        string tg;
        opcode = 3'(op);
        nxt = model_next(exp_a, op);
        tg = tag_for(exp_a, nxt);
        if (rnd && exp_a != 3) tg = {tg, " R8"};
        @(negedge clk);
        chk({tg, " uaddr"}, int'(uaddr), nxt);
        chk("R2 ctrl", int'(ctrl), int'(exp_ctrl(nxt)));
        exp_a = nxt;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 reset uaddr", int'(uaddr), 0);
        chk("R1 reset ctrl", int'(ctrl), int'(exp_ctrl(0)));
        rst = 1'b0;
        exp_a = 0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();
        // Directed: each opcode held through fetch and its routine.
        for (int op = 0; op < 8; op++) begin
            for (int c = 0; c < 4 + t_len(op); c++) step(op, 1'b0);
            chk("R6 back at fetch", exp_a, 0);
        end
        // Reset in the middle of the longest routine.
        for (int c = 0; c < 6; c++) step(5, 1'b0);
        do_reset();
        // Random opcodes changing every cycle.
        for (int c = 0; c < 800; c++) step(int'($urandom_range(7, 0)), 1'b1);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule